// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block is the control unit of a small processor core that sits between the instruction boundary and the next fetch. It owns the instruction pointer, the stack pointer and a two-bit control word. The control word holds a global interrupt-enable flag and a supervisor-mode flag. The core reports each finished instruction with `instr_done`, together with a class code and the next instruction address that its datapath computed. At that boundary the sequencer decides whether a pending request is taken before the next fetch.

Taking a request starts a two-cycle entry sequence. The control word is written to the stack first, then the instruction pointer. The pointer is then loaded with the handler address, and the core is forced into supervisor mode with interrupts masked. The return class runs the reverse. It performs two stack reads, restores the pointer and the control word, and may go straight into a new entry when a request is still waiting.

The enable and disable classes change the enable flag only in supervisor mode. In user mode they are dropped and flagged with a fault pulse. While `busy` is high, the core must hold off its fetch; any `instr_done` seen in that time is ignored. The memory port returns read data one cycle after a read strobe.

Top module: `intr_sequencer`

## Requirements
- R1: After reset, `ip` is RESET_IP, `sp` is STACK_TOP, `cr_sup` is 1, `cr_ie` is 0, and `busy`, `mem_we` and `mem_re` are 0.
- R2: A request is taken only in a cycle where `instr_done` is high and `busy` is low. A request with interrupts enabled and no finished instruction leaves `busy` low and causes no stack traffic.
- R3: A one-cycle pulse on `irq_in` is latched as pending. It stays pending while interrupts are disabled. It is taken at the first instruction boundary where the enable flag, after that instruction's effect, is 1. This includes the boundary of the enable instruction itself.
- R4: Entry writes the control word first, then `ip`, in the two cycles after the boundary. The control word is zero-extended, with enable in bit 0 and supervisor in bit 1. The two writes go to `sp-1` and `sp-2`, so the stack grows downward and `sp` is predecremented. `sp` ends two lower. The `ip` that is pushed is the `next_ip` of the boundary instruction.
- R5: After entry, `ip` is HANDLER_VEC, `cr_sup` is 1 and `cr_ie` is 0. `irq_ack` is high during the cycle that pushes `ip`.
- R6: The return class (code 3) reads `ip` from `sp`, then the control word from `sp+1`. The read data arrives one cycle after each strobe. `sp` ends two higher, and `ip`, `cr_ie` and `cr_sup` take the popped values.
- R7: In supervisor mode, enable (code 1) sets `cr_ie` and disable (code 2) clears it.
- R8: In user mode, enable and disable leave `cr_ie` unchanged. `priv_fault` is high for exactly the cycle after that boundary.
- R9: With the enable flag set inside a handler, a new request nests. Its entry pushes below the earlier frame, and a return unwinds to the handler.
- R10: `instr_done` is ignored while `busy` is high. Neither `ip` nor the control word take its effect.
- R11: If the return restores the enable flag as 1 while a request is pending, entry follows at once, without waiting for another instruction.
- R12: A normal instruction (code 0), and any enable or disable, loads `ip` from `next_ip` at the boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 1 | Interrupt request, latched as pending |
| instr_done | input | 1 | Current instruction finished its execute phase |
| instr_kind | input | 2 | 0 normal, 1 enable, 2 disable, 3 return |
| next_ip | input | W | Address of the next instruction from the datapath |
| mem_rdata | input | W | Stack read data, valid the cycle after `mem_re` |
| ip | output | W | Instruction pointer |
| sp | output | W | Stack pointer |
| cr_ie | output | 1 | Interrupt enable flag |
| cr_sup | output | 1 | Supervisor mode flag |
| busy | output | 1 | Entry or return sequence in progress |
| irq_ack | output | 1 | Entry is completing this cycle |
| priv_fault | output | 1 | User-mode enable or disable was refused |
| mem_we | output | 1 | Stack write strobe |
| mem_re | output | 1 | Stack read strobe |
| mem_addr | output | W | Stack access address |
| mem_wdata | output | W | Stack write data |

## Verification
Entry is tried from four starting points: a request pended under a mask and released by an enable, a request arriving with interrupts already on, a request raised inside a handler, and a request raised from user mode. Together these separate the boundary test that uses the post-instruction enable flag from one that uses the stale flag. They also show that the pushed control word is the current one rather than the forced one. Returns are tried both plainly and with a request waiting, which shows whether the tail entry keys off the popped enable bit. User-mode enable and disable, plus instruction strobes held during a sequence, show that refused or ignored inputs leave no trace on the flags or the pointer.

// File: rtl/intr_sequencer.sv
module intr_sequencer #(
  parameter int W = 16,
  parameter logic [W-1:0] RESET_IP    = 16'h0100,
  parameter logic [W-1:0] STACK_TOP   = 16'h00F0,
  parameter logic [W-1:0] HANDLER_VEC = 16'h0040
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         irq_in,
  input  logic         instr_done,
  input  logic [1:0]   instr_kind,
  input  logic [W-1:0] next_ip,
  input  logic [W-1:0] mem_rdata,
  output logic [W-1:0] ip,
  output logic [W-1:0] sp,
  output logic         cr_ie,
  output logic         cr_sup,
  output logic         busy,
  output logic         irq_ack,
  output logic         priv_fault,
  output logic         mem_we,
  output logic         mem_re,
  output logic [W-1:0] mem_addr,
  output logic [W-1:0] mem_wdata
);

  typedef enum logic [2:0] {
    S_RUN, S_PUSH_CR, S_PUSH_IP, S_POP_IP, S_POP_CR, S_POP_END
  } state_t;

  localparam logic [1:0] K_NORM = 2'd0;
  localparam logic [1:0] K_STI  = 2'd1;
  localparam logic [1:0] K_CLI  = 2'd2;
  localparam logic [1:0] K_RET  = 2'd3;

  state_t st;
  logic   pend;

  wire at_bnd   = instr_done && (st == S_RUN);
  wire is_sti   = instr_kind == K_STI;
  wire is_cli   = instr_kind == K_CLI;
  wire is_ret   = instr_kind == K_RET;
  wire ie_after = (cr_sup && is_sti) ? 1'b1 :
                  (cr_sup && is_cli) ? 1'b0 : cr_ie;
  wire take_bnd = at_bnd && !is_ret && pend && ie_after;
  wire take_ret = (st == S_POP_END) && pend && mem_rdata[0];
  wire take     = take_bnd || take_ret;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_RUN;
      pend       <= 1'b0;
      ip         <= RESET_IP;
      sp         <= STACK_TOP;
      cr_ie      <= 1'b0;
      cr_sup     <= 1'b1;
      priv_fault <= 1'b0;
    end else begin
      pend       <= irq_in || (pend && !take);
      priv_fault <= at_bnd && (is_sti || is_cli) && !cr_sup;
      case (st)
        S_RUN: if (at_bnd) begin
          if (is_ret) st <= S_POP_IP;
          else begin
            ip    <= next_ip;
            cr_ie <= ie_after;
            if (take_bnd) st <= S_PUSH_CR;
          end
        end
        S_PUSH_CR: begin
          sp     <= sp - 1'b1;
          cr_sup <= 1'b1;
          cr_ie  <= 1'b0;
          st     <= S_PUSH_IP;
        end
        S_PUSH_IP: begin
          sp <= sp - 1'b1;
          ip <= HANDLER_VEC;
          st <= S_RUN;
        end
        S_POP_IP: begin
          sp <= sp + 1'b1;
          st <= S_POP_CR;
        end
        S_POP_CR: begin
          sp <= sp + 1'b1;
          ip <= mem_rdata;
          st <= S_POP_END;
        end
        S_POP_END: begin
          cr_ie  <= mem_rdata[0];
          cr_sup <= mem_rdata[1];
          st     <= take_ret ? S_PUSH_CR : S_RUN;
        end
        default: st <= S_RUN;
      endcase
    end
  end

  assign busy      = st != S_RUN;
  assign irq_ack   = st == S_PUSH_IP;
  assign mem_we    = (st == S_PUSH_CR) || (st == S_PUSH_IP);
  assign mem_re    = (st == S_POP_IP) || (st == S_POP_CR);
  assign mem_addr  = mem_we ? sp - 1'b1 : sp;
  assign mem_wdata = (st == S_PUSH_CR) ? {{(W-2){1'b0}}, cr_sup, cr_ie} : ip;

  AST_NO_RW_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re)); // R4
  AST_PUSH_DECR: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> sp == $past(sp) - 1'b1); // R4
  AST_POP_INCR: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> sp == $past(sp) + 1'b1); // R6
  AST_STACK_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || mem_re) |-> busy); // R2
  AST_ENTRY_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> (!cr_ie && cr_sup && ip == HANDLER_VEC)); // R5
  AST_FAULT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    priv_fault |-> ($past(instr_done) && !$past(busy) && !$past(cr_sup))); // R8
  AST_USER_IE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_done && !busy && !cr_sup && (is_sti || is_cli)) |=> $stable(cr_ie)); // R8
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !irq_ack && !mem_re && instr_done) |=> $stable(ip)); // R10

endmodule

// File: tb/intr_sequencer_test.sv
module intr_sequencer_test;
  localparam int W = 16;
  localparam logic [W-1:0] VEC = 16'h0040;

  logic clk = 0, rst_n = 0, irq_in = 0, instr_done = 0;
  logic [1:0] instr_kind = 0;
  logic [W-1:0] next_ip = 0, mem_rdata;
  logic [W-1:0] ip, sp, mem_addr, mem_wdata;
  logic cr_ie, cr_sup, busy, irq_ack, priv_fault, mem_we, mem_re;

  logic [W-1:0] mem [0:255];
  logic pre_we = 0;
  logic [7:0] pre_addr = 0;
  logic [W-1:0] pre_data = 0;

  int checks = 0, fails = 0, cycles = 0;
  logic [31:0] expq [$];

  always #2 clk = ~clk;

  intr_sequencer uut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .instr_done(instr_done),
    .instr_kind(instr_kind), .next_ip(next_ip), .mem_rdata(mem_rdata),
    .ip(ip), .sp(sp), .cr_ie(cr_ie), .cr_sup(cr_sup), .busy(busy),
    .irq_ack(irq_ack), .priv_fault(priv_fault), .mem_we(mem_we),
    .mem_re(mem_re), .mem_addr(mem_addr), .mem_wdata(mem_wdata));

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    else if (pre_we) mem[pre_addr] <= pre_data;
    mem_rdata <= mem[mem_addr[7:0]];
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // scoreboard monitor: compare each stack write against the expected queue
  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      if (expq.size() == 0) chk("R4 unexpected write", {mem_addr, mem_wdata}, 32'hxxxxxxxx);
      else chk("R4 push", {mem_addr, mem_wdata}, expq.pop_front());
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic expect_push(input logic [W-1:0] a, input logic [W-1:0] d);
    expq.push_back({a, d});
  endtask

  task automatic do_instr(input logic [1:0] k, input logic [W-1:0] nip);
    @(negedge clk); instr_done = 1; instr_kind = k; next_ip = nip;
    @(negedge clk); instr_done = 0; instr_kind = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 20 && busy; i++) @(negedge clk);
  endtask

  task automatic pulse_irq();
    @(negedge clk); irq_in = 1;
    @(negedge clk); irq_in = 0;
  endtask

  task automatic preload(input logic [7:0] a, input logic [W-1:0] d);
    @(negedge clk); pre_we = 1; pre_addr = a; pre_data = d;
    @(negedge clk); pre_we = 0;
  endtask

  task automatic chk_state(input string req, input logic [W-1:0] eip,
                           input logic [W-1:0] esp, input logic [1:0] ecr);
    chk(req, ip, eip);
    chk(req, sp, esp);
    chk(req, {cr_sup, cr_ie}, ecr);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk_state("R1", 16'h0100, 16'h00F0, 2'b10);
    chk("R1 busy", {busy, mem_we, mem_re}, 0);
    rst_n = 1;
    @(negedge clk);
    chk_state("R1 held", 16'h0100, 16'h00F0, 2'b10);

    // R12 normal instruction advances ip
    do_instr(2'd0, 16'h0101);
    chk("R12 ip", ip, 16'h0101);

    // R3 request pends under mask
    pulse_irq();
    do_instr(2'd0, 16'h0102);
    chk("R3 masked not taken", busy, 0);

    // R3 R7 enable releases pending request at its own boundary
    expect_push(16'h00EF, 16'h0003);
    expect_push(16'h00EE, 16'h0103);
    do_instr(2'd1, 16'h0103);
    chk("R3 taken at enable", busy, 1);
    wait_idle();
    chk_state("R5 entry", VEC, 16'h00EE, 2'b10);

    // R7 enable in supervisor; R2 no entry without boundary
    do_instr(2'd1, 16'h0041);
    chk("R7 sti", cr_ie, 1);
    pulse_irq();
    for (int i = 0; i < 3; i++) begin
      chk("R2 no boundary", {busy, mem_we}, 0);
      @(negedge clk);
    end

    // R9 nested entry, R10 strobes ignored while busy
    expect_push(16'h00ED, 16'h0003);
    expect_push(16'h00EC, 16'h0050);
    @(negedge clk); instr_done = 1; instr_kind = 2'd0; next_ip = 16'h0050;
    @(negedge clk); instr_kind = 2'd1; next_ip = 16'h9999;
    chk("R9 nested taken", busy, 1);
    @(negedge clk); chk("R5 irq_ack", irq_ack, 1);
    @(negedge clk); instr_done = 0; instr_kind = 0;
    wait_idle();
    chk_state("R10 R9 nested", VEC, 16'h00EC, 2'b10);

    // R6 return unwinds to first handler
    do_instr(2'd3, 16'h7777);
    wait_idle();
    chk_state("R6 R9 unwind", 16'h0050, 16'h00EE, 2'b11);

    // R7 disable, then R11 tail entry on return
    do_instr(2'd2, 16'h0051);
    chk("R7 cli", cr_ie, 0);
    pulse_irq();
    expect_push(16'h00EF, 16'h0003);
    expect_push(16'h00EE, 16'h0103);
    do_instr(2'd3, 16'h7777);
    wait_idle();
    chk_state("R11 tail entry", VEC, 16'h00EE, 2'b10);
    do_instr(2'd3, 16'h7777);
    wait_idle();
    chk_state("R6 return", 16'h0103, 16'h00F0, 2'b11);

    // drop to user mode through a crafted frame
    preload(8'hF0, 16'h0200);
    preload(8'hF1, 16'h0001);
    do_instr(2'd3, 16'h7777);
    wait_idle();
    chk_state("R6 to user", 16'h0200, 16'h00F2, 2'b01);

    // R8 user disable refused
    do_instr(2'd2, 16'h0201);
    chk("R8 fault pulse", priv_fault, 1);
    chk_state("R8 cli ignored", 16'h0201, 16'h00F2, 2'b01);
    @(negedge clk);
    chk("R8 fault one cycle", priv_fault, 0);

    // R5 entry from user forces supervisor
    pulse_irq();
    expect_push(16'h00F1, 16'h0001);
    expect_push(16'h00F0, 16'h0202);
    do_instr(2'd0, 16'h0202);
    wait_idle();
    chk_state("R5 user entry", VEC, 16'h00F0, 2'b10);

    // R8 user enable refused, pending stays untaken
    preload(8'hF1, 16'h0000);
    do_instr(2'd3, 16'h7777);
    wait_idle();
    chk_state("R6 user masked", 16'h0202, 16'h00F2, 2'b00);
    pulse_irq();
    do_instr(2'd1, 16'h0203);
    chk("R8 sti fault", priv_fault, 1);
    chk("R8 sti ignored", {busy, cr_ie}, 0);
    @(negedge clk);
    chk("R8 no entry", {busy, mem_we}, 0);

    chk("R4 all pushes seen", expq.size(), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule